// File: doc/BRIEF.md
# Nibble-Access Reload Timer

This block is an 8-bit up-counting timer for a processor whose data bus is four bits wide. Software sets the reload value and reads the running count one 4-bit digit at a time through a small register bus. The count advances on pulses from a prescaler that divides the system clock by one of eight power-of-two ratios. The ratio is chosen by a 3-bit mode register.

When the count steps from 0xFF to 0x00, the counter takes the reload value instead and raises a sticky interrupt request. The request stays set until software pulses a clear strobe. The reload value is written low digit first; writing the high digit commits the full byte and loads it into the counter at once. The count is read high digit first. That read captures the low digit in a holding latch, so the low-digit read that follows matches the high digit even though the counter kept running.

Top module: `ntmr_top`

## Requirements
- R1: After reset the count, the reload value, the low-digit holding latch and the mode register all read zero, and irq_o is low.
- R2: A write to address 0 (reload low digit) changes only bits 3:0 of the reload value. It does not alter the running count.
- R3: A write to address 1 (reload high digit) sets bits 7:4 of the reload value and loads {written digit, stored low digit} into the counter on the same clock edge. This load takes priority over a prescaler tick.
- R4: The counter increments by exactly one for each synchronized prescaler pulse and holds its value between pulses.
- R5: Mode codes 0 to 7 (address 4, bits 2:0) select division by 2^11, 2^9, 2^7, 2^5, 2^3, 2^2, 2^1 and 2^0, in that order.
- R6: A pulse that arrives while the count is 0xFF loads the reload value into the counter and sets irq_o on the same edge.
- R7: irq_o stays high until irq_clr_i is pulsed. If a clear and a wrap happen in the same cycle, irq_o stays high.
- R8: A read of address 3 returns count bits 7:4 and latches count bits 3:0. A read of address 2 returns the latched digit. A read of address 4 returns {0, mode}. Reads of other addresses return zero, and rdata_o is zero when rd_en_i is low.
- R9: A mode write restarts the prescaler from zero. With ratio 2^k, after the mode write edge E0 the count increments on edges E0 + m*2^k + 1 for m = 1, 2, 3 and so on.
- R10: In mode 7 the counter increments on every clock edge, starting from the second edge after the mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address (0 reload low, 1 reload high, 2 count low, 3 count high, 4 mode) |
| wdata_i | input | 4 | Write data digit |
| rdata_o | output | 4 | Read data digit, valid in the cycle that rd_en_i is high |
| irq_clr_i | input | 1 | Clears the interrupt request |
| irq_o | output | 1 | Sticky overflow interrupt request |

## Verification
The hardest case to reach from the ports is a wrap and a clear strobe landing on the same edge. The bench forces it by selecting divide-by-1 and loading 0xFE, which puts the wrap at a known edge, and then issues the clear on that exact edge. The low-digit latch is stressed in the same way: in fast modes the count moves between the two digit reads, so a latch that failed to hold would return the wrong digit. Random trials cover all eight ratios with random reload values and wait lengths, and are checked against a tick-counting model. One long directed wait reaches the slowest ratio.

// File: rtl/ntmr_pkg.sv
package ntmr_pkg;
  localparam int unsigned DIG_W  = 4;
  localparam int unsigned CNT_W  = 2 * DIG_W;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned PSC_W  = 11;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD_LO = 3'd0,
    A_LOAD_HI = 3'd1,
    A_CNT_LO  = 3'd2,
    A_CNT_HI  = 3'd3,
    A_MODE    = 3'd4
  } reg_addr_e;

  // codes 0..3 step the shift down by two from 11, codes 4..7 by one from 3
  function automatic int unsigned mode_shift(input logic [MODE_W-1:0] code);
    int unsigned c;
    c = int'(code);
    return (c < 4) ? (PSC_W - 2 * c) : (7 - c);
  endfunction
endpackage

// File: rtl/ntmr_psc.sv
module ntmr_psc
  import ntmr_pkg::*;
#(
  parameter int unsigned P_W = PSC_W,
  parameter int unsigned M_W = MODE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic [M_W-1:0] mode_i,
  output logic           tick_o,
  output logic [P_W-1:0] psc_o
);
  logic [P_W-1:0] psc_q;
  logic [P_W-1:0] mask;
  logic           tick_raw;
  logic           tick_q;

  always_comb begin
    mask     = (P_W'(1) << mode_shift(mode_i)) - P_W'(1);
    tick_raw = &(psc_q | ~mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart_i) begin
      psc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      psc_q  <= psc_q + P_W'(1);
      tick_q <= tick_raw;
    end
  end

  assign tick_o = tick_q;
  assign psc_o  = psc_q;
endmodule

// File: rtl/ntmr_cnt.sv
module ntmr_cnt
  import ntmr_pkg::*;
#(
  parameter int unsigned D_W = DIG_W,
  localparam int unsigned C_W = 2 * D_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           lo_wr_i,
  input  logic           hi_wr_i,
  input  logic [D_W-1:0] wdata_i,
  input  logic           irq_clr_i,
  output logic [C_W-1:0] cnt_o,
  output logic [C_W-1:0] load_o,
  output logic           wrap_o,
  output logic           irq_o
);
  logic [C_W-1:0] cnt_q;
  logic [C_W-1:0] load_q;
  logic           irq_q;
  logic           wrap;

  assign wrap = tick_i && (&cnt_q) && !hi_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
    end else if (lo_wr_i) begin
      load_q[D_W-1:0] <= wdata_i;
    end else if (hi_wr_i) begin
      load_q[C_W-1:D_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hi_wr_i) begin
      cnt_q <= {wdata_i, load_q[D_W-1:0]};
    end else if (wrap) begin
      cnt_q <= load_q;
    end else if (tick_i) begin
      cnt_q <= cnt_q + C_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (wrap)      irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign wrap_o = wrap;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ntmr_rdp.sv
module ntmr_rdp
  import ntmr_pkg::*;
#(
  parameter int unsigned D_W = DIG_W,
  parameter int unsigned M_W = MODE_W,
  parameter int unsigned A_W = ADDR_W,
  localparam int unsigned C_W = 2 * D_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_en_i,
  input  logic [A_W-1:0] addr_i,
  input  logic [C_W-1:0] cnt_i,
  input  logic [M_W-1:0] mode_i,
  output logic [D_W-1:0] latch_o,
  output logic [D_W-1:0] rdata_o
);
  logic [D_W-1:0] lo_latch_q;
  logic           hi_rd;

  assign hi_rd = rd_en_i && (addr_i == A_W'(A_CNT_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_latch_q <= '0;
    else if (hi_rd) lo_latch_q <= cnt_i[D_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_W'(A_CNT_HI): rdata_o = cnt_i[C_W-1:D_W];
        A_W'(A_CNT_LO): rdata_o = lo_latch_q;
        A_W'(A_MODE):   rdata_o = D_W'(mode_i);
        default:        rdata_o = '0;
      endcase
    end
  end

  assign latch_o = lo_latch_q;
endmodule

// File: rtl/ntmr_top.sv
module ntmr_top
  import ntmr_pkg::*;
#(
  parameter int unsigned D_W = DIG_W,
  parameter int unsigned M_W = MODE_W,
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned P_W = PSC_W,
  localparam int unsigned C_W = 2 * D_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [A_W-1:0] addr_i,
  input  logic [D_W-1:0] wdata_i,
  output logic [D_W-1:0] rdata_o,
  input  logic           irq_clr_i,
  output logic           irq_o
);
  logic           lo_wr, hi_wr, mode_wr;
  logic [M_W-1:0] mode_q;
  logic           tick;
  logic [P_W-1:0] psc;
  logic [C_W-1:0] cnt;
  logic [C_W-1:0] load;
  logic           wrap;
  logic [D_W-1:0] latch;

  assign lo_wr   = wr_en_i && (addr_i == A_W'(A_LOAD_LO));
  assign hi_wr   = wr_en_i && (addr_i == A_W'(A_LOAD_HI));
  assign mode_wr = wr_en_i && (addr_i == A_W'(A_MODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_wr) mode_q <= wdata_i[M_W-1:0];
  end

  ntmr_psc #(.P_W(P_W), .M_W(M_W)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(mode_wr),
    .mode_i   (mode_q),
    .tick_o   (tick),
    .psc_o    (psc)
  );

  ntmr_cnt #(.D_W(D_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .lo_wr_i  (lo_wr),
    .hi_wr_i  (hi_wr),
    .wdata_i  (wdata_i),
    .irq_clr_i(irq_clr_i),
    .cnt_o    (cnt),
    .load_o   (load),
    .wrap_o   (wrap),
    .irq_o    (irq_o)
  );

  ntmr_rdp #(.D_W(D_W), .M_W(M_W), .A_W(A_W)) u_rdp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en_i),
    .addr_i (addr_i),
    .cnt_i  (cnt),
    .mode_i (mode_q),
    .latch_o(latch),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/ntmr_chk.sv
module ntmr_chk
  import ntmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DIG_W-1:0]  wdata_i,
  input logic              irq_clr_i,
  input logic              irq_o,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load,
  input logic [MODE_W-1:0] mode_q,
  input logic [PSC_W-1:0]  psc,
  input logic [DIG_W-1:0]  latch
);
  logic lo_w, hi_w, md_w, hi_r;
  assign lo_w = wr_en_i && addr_i == ADDR_W'(A_LOAD_LO);
  assign hi_w = wr_en_i && addr_i == ADDR_W'(A_LOAD_HI);
  assign md_w = wr_en_i && addr_i == ADDR_W'(A_MODE);
  assign hi_r = rd_en_i && addr_i == ADDR_W'(A_CNT_HI);

  p_lo_keeps_cnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_w && !tick) |=> cnt == $past(cnt));
  p_hi_loads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_w |=> cnt == {$past(wdata_i), $past(load[DIG_W-1:0])});
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !hi_w && cnt != '1) |=> cnt == $past(cnt) + 8'd1);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !hi_w) |=> $stable(cnt));
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !hi_w && cnt == '1) |=> (cnt == $past(load)) && irq_o);
  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  p_irq_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !(tick && !hi_w && cnt == '1)) |=> !irq_o);
  p_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_r |=> latch == $past(cnt[DIG_W-1:0]));
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_w |=> (psc == '0) && !tick);
  p_div1_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd7 && !md_w) |=> tick);
endmodule

bind ntmr_top ntmr_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_clr_i(irq_clr_i),
  .irq_o    (irq_o),
  .tick     (tick),
  .cnt      (cnt),
  .load     (load),
  .mode_q   (mode_q),
  .psc      (psc),
  .latch    (latch)
);

// File: tb/tb_ntmr_top.sv
module tb_ntmr_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0, irq_clr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [3:0] rdata_o;
  logic       irq_o;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  ntmr_top dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input bit wr, input bit rd, input logic [2:0] a, input logic [3:0] d,
                        input bit clr, output logic [3:0] rd_val, output logic irq_val);
    @(negedge clk_i);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d; irq_clr_i = clr;
    #1;
    rd_val = rdata_o; irq_val = irq_o;
    @(posedge clk_i);
    #1;
    wr_en_i = 0; rd_en_i = 0; irq_clr_i = 0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    logic [3:0] r; logic q;
    bus_op(1, 0, a, d, 0, r, q);
  endtask

  task automatic rd_cnt(output logic [7:0] v, output logic q);
    logic [3:0] h, l; logic q2;
    bus_op(0, 1, 3'd3, 4'h0, 0, h, q);
    bus_op(0, 1, 3'd2, 4'h0, 0, l, q2);
    v = {h, l};
  endtask

  task automatic clr_irq();
    logic [3:0] r; logic q;
    bus_op(0, 0, 3'd0, 4'h0, 1, r, q);
  endtask

  function automatic int shift_of(input int code);
    return (code < 4) ? 11 - 2 * code : 7 - code;
  endfunction

  function automatic int ticks_by(input int k, input int n);
    return (n < 1) ? 0 : ((n - 1) >> k);
  endfunction

  function automatic logic [7:0] model_cnt(input logic [7:0] ld, input int t);
    logic [7:0] c = ld;
    for (int i = 0; i < t; i++) c = (c == 8'hFF) ? ld : c + 8'd1;
    return c;
  endfunction

  function automatic bit model_wrap(input logic [7:0] ld, input int t);
    logic [7:0] c = ld;
    for (int i = 0; i < t; i++) begin
      if (c == 8'hFF) return 1'b1;
      c = c + 8'd1;
    end
    return 1'b0;
  endfunction

  // clear, stage low digit, write mode (E0), commit high digit (E1), wait w edges, read
  task automatic trial(input int code, input logic [7:0] ld, input int w, input string tag);
    logic [7:0] v; logic q; int t;
    clr_irq();
    wr(3'd0, ld[3:0]);
    wr(3'd4, 4'(code));
    wr(3'd1, ld[7:4]);
    repeat (w) @(posedge clk_i);
    rd_cnt(v, q);
    t = ticks_by(shift_of(code), 1 + w);
    chk(v == model_cnt(ld, t), tag, v, model_cnt(ld, t));
    chk(q == model_wrap(ld, t), {tag, " irq"}, q, model_wrap(ld, t));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] r; logic q; logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state: latch before any high read, then count, mode, irq
    bus_op(0, 1, 3'd2, 4'h0, 0, r, q);
    chk(r == 4'h0, "R1 latch", r, 0);
    chk(q == 1'b0, "R1 irq", q, 0);
    rd_cnt(v, q);
    chk(v == 8'h00, "R1 count", v, 0);
    bus_op(0, 1, 3'd4, 4'h0, 0, r, q);
    chk(r == 4'h0, "R1 mode", r, 0);
    bus_op(0, 1, 3'd6, 4'h0, 0, r, q);
    chk(r == 4'h0, "R8 unmapped read", r, 0);

    // R2 and R3 in the slowest mode where no tick occurs
    trial(0, 8'h5A, 10, "R3 commit");
    wr(3'd0, 4'h3);
    rd_cnt(v, q);
    chk(v == 8'h5A, "R2 low write keeps count", v, 8'h5A);
    wr(3'd1, 4'hC);
    rd_cnt(v, q);
    chk(v == 8'hC3, "R3 high write loads", v, 8'hC3);
    bus_op(0, 1, 3'd4, 4'h0, 0, r, q);
    chk(r == 4'h0, "R8 mode readback", r, 0);

    // R5 and R9 at every ratio; R8 latch checked while counting fast
    for (int c = 0; c < 8; c++) begin
      trial(c, 8'h20, (1 << shift_of(c)) * 3 % 700 + 5, "R5 ratio");
      bus_op(0, 1, 3'd4, 4'h0, 0, r, q);
      chk(r == 4'(c), "R8 mode readback", r, c);
    end
    trial(0, 8'h10, 4100, "R9 slowest two ticks");
    trial(7, 8'h00, 1, "R10 first edge no step");
    trial(7, 8'h00, 9, "R10 every edge");
    trial(6, 8'hF0, 40, "R6 wrap reload");
    trial(7, 8'hFF, 5, "R6 reload FF");

    // R7: wrap and clear on the same edge (mode 7, reload FE, wrap at E3)
    clr_irq();
    wr(3'd0, 4'hE);
    wr(3'd4, 4'h7);
    wr(3'd1, 4'hF);
    @(posedge clk_i);
    clr_irq();
    chk(irq_o == 1'b1, "R7 wrap beats clear", irq_o, 1);
    clr_irq();
    chk(irq_o == 1'b0, "R7 clear", irq_o, 0);
    wr(3'd4, 4'h0);
    trial(6, 8'hFE, 20, "R7 set");
    repeat (30) @(posedge clk_i);
    chk(irq_o == 1'b1, "R7 sticky", irq_o, 1);

    // random mix, R4 R6 R8 R9
    for (int i = 0; i < 30; i++) begin
      trial($urandom % 8, 8'($urandom), $urandom % 400, "R4 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule